// File: doc/BRIEF.md
# Spread-Spectrum Physical-Layer Frame Transmitter

This block turns one packet payload into the serial chip stream of a direct-sequence spread-spectrum physical layer. A single `start` pulse carries the payload length and a band choice. The block then emits zero bytes for the preamble, the start delimiter, the length byte, the payload bytes drawn from a valid/ready byte source, and a 16-bit check sequence that the block computes itself. Every byte is cut into two 4-bit symbols. Each symbol is replaced by a 16-chip code word, and the chips leave one at a time on a valid/ready chip port.

Back-pressure works the same way on both streams. A transfer happens in a cycle where valid and ready are both high. The block holds `chip_valid` and `chip_out` steady until `chip_ready` is seen. `pl_ready` is high only while payload is being taken and the chip side has room for the byte. A source may lower `pl_valid` at any time, and this only stalls the frame.

A separate receive-side checker runs the same CRC over bytes that arrive as a received frame (payload followed by the two check bytes). It reports on `rx_crc_ok` whether the frame is consistent.

Top module: `dsss_frame_tx`

## Requirements
- R1: After an accepted start, the frame opens with all-zero preamble bytes: 4 of them when `band_low`=1 at start, 10 when `band_low`=0.
- R2: The preamble is followed directly by the delimiter byte 0xA7, then by one byte equal to `frame_len`.
- R3: Exactly `frame_len` payload bytes are taken, in order, and sent unchanged. `pl_ready` is never high outside the payload phase.
- R4: The last two bytes are the CRC of the payload only, low byte first. The CRC uses polynomial x^16+x^12+x^5+1, processed LSB-first in reflected form (0x8408), starting from 0 with no final inversion. For the ASCII payload "123456789" the CRC is 0x2189.
- R5: Each byte is sent as its low nibble and then its high nibble. A symbol s becomes the word W(s) = 0xD9C3 rotated left by s bit positions, and its chips are sent from bit 0 to bit 15.
- R6: While `chip_valid`=1 and `chip_ready`=0, both `chip_valid` and `chip_out` hold their values into the next cycle. No chip is lost or repeated.
- R7: A start with `frame_len` > 127 raises `len_err` for exactly the cycle after the start. No chip is sent and `busy` stays low.
- R8: `busy` is high from the cycle after an accepted start until the frame ends. `done` is high for exactly one cycle: the cycle after the last chip of the check sequence is transferred.
- R9: A `start` pulse while `busy`=1 is ignored. The frame in progress is unchanged, and no second frame follows it.
- R10: `rx_clear` sets the receive CRC to 0. Each `rx_byte_valid` cycle folds `rx_byte` into it. `rx_crc_ok` is 1 exactly when the folded CRC is 0, which is the case after a payload followed by its correct two check bytes.
- R11: During reset, `chip_valid`, `pl_ready`, `busy`, `done` and `len_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-of-frame request, sampled while idle |
| band_low | input | 1 | 1: short preamble, 0: long preamble |
| frame_len | input | 8 | Payload length, legal range 0..127 |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte valid |
| pl_ready | output | 1 | Payload byte accepted this cycle when valid |
| chip_out | output | 1 | Current chip |
| chip_valid | output | 1 | Chip valid |
| chip_ready | input | 1 | Sink accepts the chip |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| len_err | output | 1 | One-cycle pulse: start rejected because the length is too large |
| rx_clear | input | 1 | Clear the receive CRC |
| rx_byte | input | 8 | Received byte |
| rx_byte_valid | input | 1 | Fold `rx_byte` into the receive CRC |
| rx_crc_ok | output | 1 | Receive CRC residue is zero |

## Verification
A wrong phase counter or phase state shows at the chip port within 32 chip transfers, because every byte of the frame spreads into a known 32-chip pattern. A short or long preamble moves the delimiter by a whole byte, and the check against the chips catches that at the first misplaced chip. A corrupted CRC register reaches the port only in the final 64 chips, so frames of random length and payload push that fault out on every frame. A lost stall shows up as a skipped or repeated chip at the next transfer. A wrong end-of-frame state shows as a missing, early or doubled `done`, or as `busy` staying high.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;
  localparam int BYTE_W   = 8;
  localparam int SYM_W    = 4;
  localparam int CHIPS    = 16;
  localparam int CRC_W    = 16;
  localparam logic [CHIPS-1:0] CHIP_BASE  = 16'hD9C3;
  localparam logic [CRC_W-1:0] CRC_REFL   = 16'h8408;
  localparam logic [BYTE_W-1:0] DELIM_BYTE = 8'hA7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_DELIM, PH_LEN, PH_PAY, PH_FCS_LO, PH_FCS_HI, PH_DRAIN
  } phase_e;

  // One byte folded into a reflected CRC, LSB first.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Symbol code word: base sequence rotated left by the symbol value.
  function automatic logic [CHIPS-1:0] chip_word(input logic [SYM_W-1:0] s);
    logic [2*CHIPS-1:0] d;
    d = {CHIP_BASE, CHIP_BASE} << s;
    return d[2*CHIPS-1:CHIPS];
  endfunction
endpackage

// File: rtl/dsss_crc16.sv
module dsss_crc16
  import dsss_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc_fold(crc, data);
  end
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
  import dsss_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] b_data,
  input  logic              b_valid,
  output logic              b_ready,
  output logic              chip_out,
  output logic              chip_valid,
  input  logic              chip_ready,
  output logic              idle
);
  localparam int IDX_W = $clog2(CHIPS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHIPS - 1);

  logic [BYTE_W-1:0] byte_q;
  logic              full;
  logic              hi_nib;
  logic [IDX_W-1:0]  idx;
  logic [SYM_W-1:0]  sym;
  logic [CHIPS-1:0]  word;
  logic              take;
  logic              last;

  assign sym        = hi_nib ? byte_q[BYTE_W-1:SYM_W] : byte_q[SYM_W-1:0];
  assign word       = chip_word(sym);
  assign chip_out   = word[idx];
  assign chip_valid = full;
  assign take       = full && chip_ready;
  assign last       = hi_nib && (idx == IDX_LAST);
  assign b_ready    = !full || (take && last);
  assign idle       = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      full   <= 1'b0;
      hi_nib <= 1'b0;
      idx    <= '0;
    end else if (!full) begin
      if (b_valid) begin
        full   <= 1'b1;
        byte_q <= b_data;
        hi_nib <= 1'b0;
        idx    <= '0;
      end
    end else if (take) begin
      idx <= idx + 1'b1;
      if (idx == IDX_LAST) hi_nib <= ~hi_nib;
      if (last) begin
        full <= b_valid;
        if (b_valid) byte_q <= b_data;
      end
    end
  end
endmodule

// File: rtl/dsss_frame_seq.sv
module dsss_frame_seq
  import dsss_tx_pkg::*;
#(
  parameter int PRE_LOW  = 4,
  parameter int PRE_HIGH = 10,
  parameter int MAX_LEN  = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              band_low,
  input  logic [BYTE_W-1:0] frame_len,
  input  logic [BYTE_W-1:0] pl_data,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [CRC_W-1:0]  crc,
  output logic              crc_clr,
  output logic              crc_en,
  output logic [BYTE_W-1:0] b_data,
  output logic              b_valid,
  input  logic              b_ready,
  input  logic              spr_idle,
  output logic              busy,
  output logic              done,
  output logic              len_err
);
  localparam int CNT_MAX = (PRE_HIGH > MAX_LEN) ? PRE_HIGH : MAX_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [BYTE_W-1:0] LEN_LIM = BYTE_W'(MAX_LEN);

  phase_e            ph;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] len_q;
  logic              fire;

  always_comb begin
    b_valid  = 1'b0;
    b_data   = '0;
    pl_ready = 1'b0;
    unique case (ph)
      PH_PRE:    b_valid = 1'b1;
      PH_DELIM:  begin b_valid = 1'b1; b_data = DELIM_BYTE; end
      PH_LEN:    begin b_valid = 1'b1; b_data = len_q; end
      PH_PAY:    begin b_valid = pl_valid; b_data = pl_data; pl_ready = b_ready; end
      PH_FCS_LO: begin b_valid = 1'b1; b_data = crc[BYTE_W-1:0]; end
      PH_FCS_HI: begin b_valid = 1'b1; b_data = crc[CRC_W-1:BYTE_W]; end
      default:   ;
    endcase
  end

  assign fire    = b_valid && b_ready;
  assign crc_clr = (ph == PH_IDLE) && start;
  assign crc_en  = (ph == PH_PAY) && fire;
  assign busy    = (ph != PH_IDLE);
  assign done    = (ph == PH_DRAIN) && spr_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      len_q   <= '0;
      len_err <= 1'b0;
    end else begin
      len_err <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          if (frame_len > LEN_LIM) begin
            len_err <= 1'b1;
          end else begin
            ph    <= PH_PRE;
            len_q <= frame_len;
            cnt   <= band_low ? CNT_W'(PRE_LOW - 1) : CNT_W'(PRE_HIGH - 1);
          end
        end
        PH_PRE: if (fire) begin
          if (cnt == '0) ph <= PH_DELIM;
          else           cnt <= cnt - 1'b1;
        end
        PH_DELIM: if (fire) ph <= PH_LEN;
        PH_LEN: if (fire) begin
          if (len_q == '0) ph <= PH_FCS_LO;
          else begin
            ph  <= PH_PAY;
            cnt <= CNT_W'(len_q - 8'd1);
          end
        end
        PH_PAY: if (fire) begin
          if (cnt == '0) ph <= PH_FCS_LO;
          else           cnt <= cnt - 1'b1;
        end
        PH_FCS_LO: if (fire) ph <= PH_FCS_HI;
        PH_FCS_HI: if (fire) ph <= PH_DRAIN;
        PH_DRAIN:  if (spr_idle) ph <= PH_IDLE;
        default:   ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsss_frame_tx.sv
module dsss_frame_tx
  import dsss_tx_pkg::*;
#(
  parameter int PRE_LOW_BYTES  = 4,
  parameter int PRE_HIGH_BYTES = 10,
  parameter int MAX_PAYLOAD    = 127
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        band_low,
  input  logic [7:0]  frame_len,
  input  logic [7:0]  pl_data,
  input  logic        pl_valid,
  output logic        pl_ready,
  output logic        chip_out,
  output logic        chip_valid,
  input  logic        chip_ready,
  output logic        busy,
  output logic        done,
  output logic        len_err,
  input  logic        rx_clear,
  input  logic [7:0]  rx_byte,
  input  logic        rx_byte_valid,
  output logic        rx_crc_ok
);
  logic [CRC_W-1:0]  tx_crc;
  logic [CRC_W-1:0]  rx_crc;
  logic              crc_clr;
  logic              crc_en;
  logic [BYTE_W-1:0] b_data;
  logic              b_valid;
  logic              b_ready;
  logic              spr_idle;

  dsss_frame_seq #(
    .PRE_LOW (PRE_LOW_BYTES),
    .PRE_HIGH(PRE_HIGH_BYTES),
    .MAX_LEN (MAX_PAYLOAD)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .band_low(band_low),
    .frame_len(frame_len), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .crc(tx_crc), .crc_clr(crc_clr), .crc_en(crc_en),
    .b_data(b_data), .b_valid(b_valid), .b_ready(b_ready),
    .spr_idle(spr_idle), .busy(busy), .done(done), .len_err(len_err)
  );

  dsss_crc16 tx_crc_i (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .data(pl_data), .crc(tx_crc)
  );

  dsss_spreader spr_i (
    .clk(clk), .rst_n(rst_n), .b_data(b_data), .b_valid(b_valid),
    .b_ready(b_ready), .chip_out(chip_out), .chip_valid(chip_valid),
    .chip_ready(chip_ready), .idle(spr_idle)
  );

  dsss_crc16 rx_crc_i (
    .clk(clk), .rst_n(rst_n), .clr(rx_clear), .en(rx_byte_valid),
    .data(rx_byte), .crc(rx_crc)
  );

  assign rx_crc_ok = (rx_crc == '0);
endmodule

// File: rtl/dsss_frame_tx_chk.sv
module dsss_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic pl_ready,
  input logic chip_out,
  input logic chip_valid,
  input logic chip_ready,
  input logic busy,
  input logic done,
  input logic len_err
);
  AST_CHIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !chip_ready) |=> (chip_valid && $stable(chip_out))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_PL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pl_ready); // R3

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (!busy && !chip_valid)); // R7

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R9
endmodule

bind dsss_frame_tx dsss_frame_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .pl_ready(pl_ready),
  .chip_out(chip_out), .chip_valid(chip_valid), .chip_ready(chip_ready),
  .busy(busy), .done(done), .len_err(len_err)
);

// File: tb/dsss_frame_tx_tb_top.sv
module dsss_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       band_low = 1'b0;
  logic [7:0] frame_len = 8'd0;
  logic [7:0] pl_data = 8'd0;
  logic       pl_valid = 1'b0;
  logic       pl_ready;
  logic       chip_out;
  logic       chip_valid;
  logic       chip_ready = 1'b0;
  logic       busy;
  logic       done;
  logic       len_err;
  logic       rx_clear = 1'b0;
  logic [7:0] rx_byte = 8'd0;
  logic       rx_byte_valid = 1'b0;
  logic       rx_crc_ok;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [7:0] pay  [0:127];
  logic [7:0] expb [0:160];
  int         nexp;
  int         npre;

  always #2.5 clk = ~clk;

  dsss_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .band_low(band_low),
    .frame_len(frame_len), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .chip_out(chip_out), .chip_valid(chip_valid),
    .chip_ready(chip_ready), .busy(busy), .done(done), .len_err(len_err),
    .rx_clear(rx_clear), .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid),
    .rx_crc_ok(rx_crc_ok)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ d[i];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic logic [15:0] m_word(input int s);
    logic [15:0] base;
    logic [15:0] w;
    base = 16'hD9C3;
    for (int i = 0; i < 16; i++) w[(i + s) % 16] = base[i];
    return w;
  endfunction

  function automatic logic m_chip(input int k);
    logic [7:0] b;
    int         sym;
    b   = expb[k / 32];
    sym = ((k % 32) < 16) ? int'(b[3:0]) : int'(b[7:4]);
    return m_word(sym)[k % 16];
  endfunction

  function automatic string area(input int k, input int len);
    int bi;
    bi = k / 32;
    if (bi < npre)            return "R1/R5 preamble chip";
    if (bi < npre + 2)        return "R2/R5 header chip";
    if (bi < npre + 2 + len)  return "R3/R5 payload chip";
    return "R4/R5 check chip";
  endfunction

  task automatic run_frame(input int len, input bit bl, input bit inject);
    logic [15:0] c;
    int k = 0;
    int pidx = 0;
    int total;
    int it = 0;
    bit prev_last = 1'b0;
    bit fin = 1'b0;
    npre = bl ? 4 : 10;
    c = 16'h0000;
    for (int i = 0; i < len; i++) c = m_crc(c, pay[i]);
    nexp = 0;
    for (int i = 0; i < npre; i++) begin expb[nexp] = 8'h00; nexp++; end
    expb[nexp] = 8'hA7; nexp++;
    expb[nexp] = 8'(len); nexp++;
    for (int i = 0; i < len; i++) begin expb[nexp] = pay[i]; nexp++; end
    expb[nexp] = c[7:0];  nexp++;
    expb[nexp] = c[15:8]; nexp++;
    total = nexp * 32;

    @(negedge clk);
    start = 1'b1; frame_len = 8'(len); band_low = bl;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(busy === 1'b1, "R8 busy after start", int'(busy), 1);
    while (!fin) begin
      bit take;
      @(negedge clk);
      chip_ready = ($urandom_range(0, 3) != 0);
      pl_valid   = (pidx < len) && ($urandom_range(0, 4) != 0);
      pl_data    = (pidx < len) ? pay[pidx] : 8'hEE;
      start      = inject && (it == 20);
      frame_len  = 8'd3;
      band_low   = ~bl;
      it++;
      #1;
      chk(done === prev_last, "R8 done timing", int'(done), int'(prev_last));
      if (done) fin = 1'b1;
      take = chip_valid && chip_ready;
      if (take) begin
        if (k < total)
          chk(chip_out === m_chip(k), area(k, len), int'(chip_out), int'(m_chip(k)));
        else
          chk(1'b0, "R8 chip after frame end", k, total);
        k++;
      end
      prev_last = take && (k == total);
      if (pl_valid && pl_ready) pidx++;
    end
    chip_ready = 1'b0; pl_valid = 1'b0; start = 1'b0;
    chk(k == total, "R5 chip count", k, total);
    chk(pidx == len, "R3 payload bytes taken", pidx, len);
    for (int i = 0; i < 6; i++) @(negedge clk);
    #1;
    chk(busy === 1'b0 && chip_valid === 1'b0, inject ? "R9 no frame from ignored start" : "R8 idle after done",
        int'({busy, chip_valid}), 0);
  endtask

  task automatic rx_feed(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_byte_valid = 1'b1;
    @(negedge clk);
    rx_byte_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk({chip_valid, pl_ready, busy, done, len_err} === 5'b0, "R11 reset outputs",
        int'({chip_valid, pl_ready, busy, done, len_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: empty payload, short preamble
    run_frame(0, 1'b1, 1'b0);
    // Directed: one byte, long preamble
    pay[0] = 8'h5A;
    run_frame(1, 1'b0, 1'b0);
    // Directed: known CRC vector, with a start pulse injected mid-frame (R9)
    for (int i = 0; i < 9; i++) pay[i] = 8'(8'h31 + i);
    begin
      logic [15:0] c;
      c = 16'h0;
      for (int i = 0; i < 9; i++) c = m_crc(c, pay[i]);
      chk(c == 16'h2189, "R4 check vector", int'(c), 16'h2189);
    end
    run_frame(9, 1'b0, 1'b1);
    // Directed: maximum length
    for (int i = 0; i < 127; i++) pay[i] = 8'($urandom);
    run_frame(127, 1'b1, 1'b0);
    // Random frames
    for (int f = 0; f < 5; f++) begin
      int l;
      l = $urandom_range(0, 127);
      for (int i = 0; i < l; i++) pay[i] = 8'($urandom);
      run_frame(l, 1'($urandom_range(0, 1)), 1'b0);
    end

    // Length rejection: 128 and 255
    for (int t = 0; t < 2; t++) begin
      bit seen;
      @(negedge clk);
      start = 1'b1; frame_len = (t == 0) ? 8'd128 : 8'd255; chip_ready = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(len_err === 1'b1, "R7 len_err raised", int'(len_err), 1);
      chk(busy === 1'b0, "R7 busy stays low", int'(busy), 0);
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); #1;
        if (chip_valid || busy || len_err) seen = 1'b1;
      end
      chk(!seen, "R7 nothing sent after rejection", int'(seen), 0);
      chip_ready = 1'b0;
    end

    // Receive checker
    for (int t = 0; t < 3; t++) begin
      logic [15:0] c;
      int l;
      l = 1 + $urandom_range(0, 30);
      for (int i = 0; i < l; i++) pay[i] = 8'($urandom);
      c = 16'h0;
      for (int i = 0; i < l; i++) c = m_crc(c, pay[i]);
      @(negedge clk); rx_clear = 1'b1;
      @(negedge clk); rx_clear = 1'b0;
      for (int i = 0; i < l; i++) rx_feed(pay[i]);
      rx_feed(c[7:0]);
      rx_feed(c[15:8]);
      #1;
      chk(rx_crc_ok === 1'b1, "R10 good frame accepted", int'(rx_crc_ok), 1);
      @(negedge clk); rx_clear = 1'b1;
      @(negedge clk); rx_clear = 1'b0;
      for (int i = 0; i < l; i++) rx_feed((i == l / 2) ? (pay[i] ^ 8'h10) : pay[i]);
      rx_feed(c[7:0]);
      rx_feed(c[15:8]);
      #1;
      chk(rx_crc_ok === 1'b0, "R10 corrupted frame flagged", int'(rx_crc_ok), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule